// File: doc/BRIEF.md
# Event Counter with Setpoint Output

This block counts rising edges on an asynchronous event input and compares the running present value against a programmable setpoint. When an increment makes the present value equal the setpoint, the match output asserts. In latched mode the output stays asserted. In pulse mode it stays asserted for a programmable number of time-base ticks. Counting carries on past the setpoint, and the output fires only once between clears.

A clear input goes through a synchronizer and must stay asserted for a programmable number of ticks before it is accepted. The accepted clear drops the output, zeroes the present value and blocks further counting. Counting resumes when the clear input is released. The present value stops at a maximum count, 999999 by default, and ignores further events there. The surrounding logic supplies a slow `tick_i` strobe, which times both the output pulse and the clear qualification.

Top module: `event_setpoint_counter`

## Requirements
- R1: Each rising edge of `count_i` increases `pv_o` by exactly 1, three clocks after the edge reaches the input. There is at most one increment per clock.
- R2: `match_o` asserts in the same clock in which an increment makes `pv_o` equal to `setpoint_i`. A setpoint of 0 never asserts it.
- R3: `pv_o` keeps incrementing past the setpoint. `match_o` does not fire again until an accepted clear.
- R4: With `latch_i`=1, `match_o` stays asserted until an accepted clear.
- R5: With `latch_i`=0 and a width of N ≥ 1, `match_o` falls one clock after the N-th tick that follows the match. With a width of 0, `match_o` is high for exactly one clock.
- R6: An accepted clear forces `pv_o` to 0 and `match_o` low. Count edges are ignored while the clear stays asserted. Counting works again after `clear_i` is released.
- R7: `clear_i` is accepted only after it has been high through `min_clear_i` ticks. A shorter clear leaves `pv_o` and `match_o` unchanged.
- R8: `pv_o` saturates at MAX_COUNT, and further count edges leave it there.
- R9: After `rst_ni`, `pv_o` is 0 and `match_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| count_i | input | 1 | Asynchronous event input |
| clear_i | input | 1 | Asynchronous clear request |
| tick_i | input | 1 | Time-base strobe, one clock wide |
| latch_i | input | 1 | 1: latched output, 0: timed pulse |
| pulse_w_i | input | PW_W | Output pulse width in ticks |
| min_clear_i | input | CW_W | Minimum clear width in ticks |
| setpoint_i | input | CNT_W | Compare value |
| pv_o | output | CNT_W | Present count value |
| match_o | output | 1 | Setpoint output |

## Verification
The counter is driven with bursts of event pulses that stop below, exactly at and beyond the setpoint. This separates a missing match, a late or early match, and a counter that stops at the setpoint. It also runs with a zero setpoint and with a setpoint the counter cannot reach. Tick sequences after a match check the pulse length against latched mode. Clears that are too short, clears held while events arrive, and a run into saturation check that clear qualification, event blocking, the count ceiling and single firing each work independently.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int DEF_MAX_COUNT = 999999;
  localparam int DEF_PW_W      = 8;
  localparam int DEF_CW_W      = 8;
endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/evc_clear_qual.sv
module evc_clear_qual #(
  parameter int CW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_s_i,
  input  logic            tick_i,
  input  logic [CW_W-1:0] min_clear_i,
  output logic            clr_q_o
);
  localparam logic [CW_W-1:0] WMax = '1;

  logic [CW_W-1:0] width_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        width_q <= '0;
    else if (!clear_s_i)                width_q <= '0;
    else if (tick_i && width_q != WMax) width_q <= width_q + 1'b1;
  end

  assign clr_q_o = clear_s_i && (width_q >= min_clear_i);
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int MAX_COUNT = 999999,
  parameter int CNT_W     = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             count_s_i,
  input  logic             clr_q_i,
  input  logic [CNT_W-1:0] setpoint_i,
  output logic [CNT_W-1:0] pv_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] PvMax = CNT_W'(MAX_COUNT);

  logic [CNT_W-1:0] pv_q;
  logic             prev_q, fired_q;
  logic             rise, at_max, step;

  assign rise   = count_s_i && !prev_q;
  assign at_max = (pv_q == PvMax);
  assign step   = rise && !clr_q_i && !at_max;
  assign hit_o  = step && !fired_q && ((pv_q + 1'b1) == setpoint_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      pv_q    <= '0;
      fired_q <= 1'b0;
    end else begin
      prev_q <= count_s_i;
      if (clr_q_i) begin
        pv_q    <= '0;
        fired_q <= 1'b0;
      end else begin
        if (step)  pv_q    <= pv_q + 1'b1;
        if (hit_o) fired_q <= 1'b1;
      end
    end
  end

  assign pv_o = pv_q;

  // R8
  pv_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) pv_q <= PvMax);
  // R1
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_q_i |=> (pv_q == $past(pv_q) || pv_q == $past(pv_q) + 1'b1));
  // R6
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) clr_q_i |=> pv_q == '0);
endmodule

// File: rtl/evc_out.sv
module evc_out #(
  parameter int PW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hit_i,
  input  logic            clr_q_i,
  input  logic            tick_i,
  input  logic            latch_i,
  input  logic [PW_W-1:0] pulse_w_i,
  output logic            match_o
);
  logic [PW_W-1:0] rem_q;
  logic            on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      rem_q <= '0;
    end else if (clr_q_i) begin
      on_q  <= 1'b0;
      rem_q <= '0;
    end else if (hit_i) begin
      on_q  <= 1'b1;
      rem_q <= pulse_w_i;
    end else if (on_q && !latch_i) begin
      if (rem_q == '0) on_q  <= 1'b0;
      else if (tick_i) rem_q <= rem_q - 1'b1;
    end
  end

  assign match_o = on_q;

  // R2
  rise_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(on_q) |-> $past(hit_i));
  // R4
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_q && latch_i && !clr_q_i && !hit_i) |=> on_q);
  // R6
  clear_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) clr_q_i |=> !on_q);
endmodule

// File: rtl/event_setpoint_counter.sv
module event_setpoint_counter
  import evc_pkg::*;
#(
  parameter int  MAX_COUNT = DEF_MAX_COUNT,
  parameter int  PW_W      = DEF_PW_W,
  parameter int  CW_W      = DEF_CW_W,
  localparam int CNT_W     = $clog2(MAX_COUNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             count_i,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic             latch_i,
  input  logic [PW_W-1:0]  pulse_w_i,
  input  logic [CW_W-1:0]  min_clear_i,
  input  logic [CNT_W-1:0] setpoint_i,
  output logic [CNT_W-1:0] pv_o,
  output logic             match_o
);
  logic [1:0] raw, synced;
  logic       clr_q, hit;

  assign raw = {clear_i, count_i};

  evc_sync #(.W(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(synced)
  );

  evc_clear_qual #(.CW_W(CW_W)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_s_i(synced[1]), .tick_i(tick_i),
    .min_clear_i(min_clear_i), .clr_q_o(clr_q)
  );

  evc_counter #(.MAX_COUNT(MAX_COUNT), .CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .count_s_i(synced[0]), .clr_q_i(clr_q),
    .setpoint_i(setpoint_i), .pv_o(pv_o), .hit_o(hit)
  );

  evc_out #(.PW_W(PW_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .clr_q_i(clr_q), .tick_i(tick_i),
    .latch_i(latch_i), .pulse_w_i(pulse_w_i), .match_o(match_o)
  );
endmodule

// File: tb/event_setpoint_counter_test.sv
module event_setpoint_counter_test;
  localparam int MAXC = 30;
  localparam int CW   = $clog2(MAXC + 1);

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          count = 1'b0, clear = 1'b0, tick = 1'b0, latch = 1'b1;
  logic [7:0]    pw = 8'd0, minc = 8'd2;
  logic [CW-1:0] sp = '0;
  logic [CW-1:0] pv;
  logic          match;
  int            n_chk = 0, n_fail = 0, hi_cnt = 0, wd = 0;

  always #10 clk = ~clk;

  event_setpoint_counter #(.MAX_COUNT(MAXC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .count_i(count), .clear_i(clear), .tick_i(tick),
    .latch_i(latch), .pulse_w_i(pw), .min_clear_i(minc), .setpoint_i(sp),
    .pv_o(pv), .match_o(match)
  );

  always @(negedge clk) if (match) hi_cnt++;

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_count(input int n);
    for (int i = 0; i < n; i++) begin
      count = 1'b1; clks(4);
      count = 1'b0; clks(4);
    end
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; clks(1);
      tick = 1'b0; clks(1);
    end
  endtask

  task automatic do_clear();
    clear = 1'b1; clks(3);
    give_ticks(int'(minc));
    clks(2);
    clear = 1'b0; clks(4);
    hi_cnt = 0;
  endtask

  // setpoint, latch, width, events, expected pv, expected match
  typedef struct packed { logic [7:0] sp; logic lt; logic [7:0] w; logic [7:0] n; logic [7:0] pv; logic m; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'd5,  1'b1, 8'd0, 8'd3, 8'd3, 1'b0},
    '{8'd5,  1'b1, 8'd0, 8'd5, 8'd5, 1'b1},
    '{8'd5,  1'b1, 8'd0, 8'd8, 8'd8, 1'b1},
    '{8'd1,  1'b0, 8'd3, 8'd1, 8'd1, 1'b1},
    '{8'd0,  1'b1, 8'd0, 8'd4, 8'd4, 1'b0},
    '{8'd31, 1'b1, 8'd0, 8'd6, 8'd6, 1'b0}
  };

  initial begin
    clks(3);
    // R9
    check("R9 pv", int'(pv), 0);
    check("R9 match", int'(match), 0);
    rst_n = 1'b1; clks(2);

    // R1 R2 R3 vector walk
    foreach (VECS[i]) begin
      do_clear();
      sp = CW'(VECS[i].sp); latch = VECS[i].lt; pw = VECS[i].w;
      pulse_count(int'(VECS[i].n));
      check("R1 pv", int'(pv), int'(VECS[i].pv));
      check("R2 match", int'(match), int'(VECS[i].m));
    end

    // R1 latency: three clocks from input change to pv change
    do_clear();
    count = 1'b1; clks(2);
    check("R1 no early step", int'(pv), 0);
    clks(1);
    check("R1 step at third clock", int'(pv), 1);
    count = 1'b0; clks(4);

    // R5 pulse width 3 ticks
    do_clear();
    sp = CW'(2); latch = 1'b0; pw = 8'd3;
    pulse_count(2);
    check("R5 on after hit", int'(match), 1);
    give_ticks(2); clks(1);
    check("R5 on before last tick", int'(match), 1);
    give_ticks(1); clks(1);
    check("R5 off after last tick", int'(match), 0);
    pulse_count(3);
    check("R3 no refire", int'(match), 0);
    check("R3 pv continues", int'(pv), 5);

    // R5 width 0: single clock
    do_clear();
    sp = CW'(1); pw = 8'd0;
    pulse_count(1);
    check("R5 one clock pulse", hi_cnt, 1);

    // R4 latched through ticks
    do_clear();
    sp = CW'(3); latch = 1'b1; pw = 8'd1;
    pulse_count(3);
    give_ticks(5);
    check("R4 latched", int'(match), 1);

    // R7 short clear ignored
    minc = 8'd5;
    clear = 1'b1; clks(3); give_ticks(2); clear = 1'b0; clks(4);
    check("R7 pv kept", int'(pv), 3);
    check("R7 match kept", int'(match), 1);

    // R6 held clear blocks counting
    minc = 8'd2;
    clear = 1'b1; clks(3); give_ticks(2); clks(2);
    check("R6 pv zero", int'(pv), 0);
    check("R6 match off", int'(match), 0);
    pulse_count(3);
    check("R6 ignored while held", int'(pv), 0);
    clear = 1'b0; clks(4);
    pulse_count(2);
    check("R6 resumes", int'(pv), 2);

    // R8 saturation, with single fire at ceiling
    do_clear();
    sp = CW'(MAXC); latch = 1'b0; pw = 8'd0;
    pulse_count(MAXC + 3);
    check("R8 saturated", int'(pv), MAXC);
    check("R3 single fire at ceiling", hi_cnt, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule